// File: doc/BRIEF.md
# SDRAM Mode Command Sequencer

This block sits between a host register interface and the control pins of up to two SDR SDRAM devices that share a command bus. The host writes one 32-bit command word through a single-cycle write strobe. The block decodes the word and places the requested control command on the bus for the devices selected in the word. The commands are clock enable, precharge of all banks, a burst of auto-refreshes, mode register load, self-refresh and power-down. A timing word, usually held in a neighbouring register, supplies the minimum spacing between steps.

The host polls a status byte while a command runs. Bit 5 of that byte reports that the sequencer is busy. Power-up initialisation is left to software, which issues the commands one at a time and waits for busy to clear between them. Data transfers and periodic refresh scheduling are handled elsewhere.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, busy is 0, both clock enables are low, both chip selects are high, the command pins (ras_n, cas_n, we_n) read 111 (NOP) and the address bus is 0.
- R2: The command word fields are as follows. Bits [2:0] hold the mode: 0 normal, 1 clock enable, 2 precharge all, 3 auto-refresh, 4 load mode, 5 self-refresh, 6 power-down. Bit 4 selects device 1 and bit 3 selects device 2. Clock enable drives high the CKE of each selected device and leaves the CKE of any other device unchanged. The CKE of device 1 is `sd_cke[0]`.
- R3: Chip select `sd_cs_n[0]` (device 1) and `sd_cs_n[1]` (device 2) go low only for the selected devices and only in a cycle that carries a command.
- R4: Precharge all drives the pins to 010 with address bit 10 high. Busy falls trp+1 clocks after the command cycle begins, where trp is timing bits [23:20].
- R5: Auto-refresh issues N+1 commands on pins 001, where N is command bits [8:5]. Successive commands are trc+2 clocks apart, where trc is timing bits [15:12]. Busy falls trc+1 clocks after the last command.
- R6: Load mode drives the pins to 000 and puts command bits [21:9] on the address bus. In that value, burst length is at address [2:0] and CAS latency is at [6:4]. Busy falls tmrd+1 clocks after the command, where tmrd is timing bits [3:0].
- R7: Self-refresh and power-down drive the CKE of the selected devices low. Normal mode drives no command and changes no CKE.
- R8: Busy is bit 5 of the status byte, and the other status bits read 0. Busy rises on the clock edge that accepts a write and stays high until the command, including every repeated refresh, is complete.
- R9: A command write that arrives while busy is high is ignored.
- R10: A write that selects no device drives no command and never raises busy.
- R11: Every command lasts exactly one clock and is followed by NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Command word |
| timing_word | input | 32 | Timing fields, sampled when a command is accepted |
| status | output | 8 | Status byte, busy at bit 5 |
| sd_cke | output | 2 | Clock enable, one per device |
| sd_cs_n | output | 2 | Chip select, one per device, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | Address bus |

## Verification
The assertions assume that the host obeys the busy flag and that the timing word and command word are stable while the write strobe is high. The assertions do not depend on the timing word holding still after a command has been accepted, because the block captures its timing fields at acceptance.

The stimulus drives every write one cycle wide, between clock edges. Apart from the one test that deliberately writes during busy, it waits for busy to clear before the next command. It changes the timing word only while the block is idle.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_CKE_ON = 3'd1,
    MODE_PALL   = 3'd2,
    MODE_AREF   = 3'd3,
    MODE_LMR    = 3'd4,
    MODE_SELF   = 3'd5,
    MODE_PDOWN  = 3'd6,
    MODE_RSVD   = 3'd7
  } mode_e;

  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    PIN_LMR  = 3'b000,
    PIN_AREF = 3'b001,
    PIN_PALL = 3'b010,
    PIN_NOP  = 3'b111
  } pin_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } state_e;
endpackage

// File: rtl/sdseq_decode.sv
module sdseq_decode
  import sdseq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int TF_W   = 4,
  parameter int RC_W   = 4
) (
  input  logic [31:0]       cmd_word,
  input  logic [31:0]       timing_word,
  output mode_e             mode,
  output logic [1:0]        tgt,
  output logic [RC_W-1:0]   rcount,
  output logic [ADDR_W-1:0] mval,
  output logic [TF_W-1:0]   t_rc,
  output logic [TF_W-1:0]   t_rp,
  output logic [TF_W-1:0]   t_mrd
);
  localparam int MODE_LSB = 9;
  localparam int RC_LSB   = 5;

  always_comb begin
    mode   = mode_e'(cmd_word[2:0]);
    tgt    = {cmd_word[3], cmd_word[4]};
    rcount = cmd_word[RC_LSB +: RC_W];
    mval   = cmd_word[MODE_LSB +: ADDR_W];
    t_mrd  = timing_word[0  +: TF_W];
    t_rc   = timing_word[12 +: TF_W];
    t_rp   = timing_word[20 +: TF_W];
  end
endmodule

// File: rtl/sdseq_timer.sv
module sdseq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (run && (cnt_q != '0));
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdseq_pins.sv
module sdseq_pins
  import sdseq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive,
  input  mode_e             mode,
  input  logic [1:0]        tgt,
  input  logic [ADDR_W-1:0] mval,
  output logic [1:0]        cke,
  output logic [1:0]        cs_n,
  output logic [2:0]        pins,
  output logic [ADDR_W-1:0] addr
);
  logic [1:0]        cke_d, cs_n_d;
  logic [2:0]        pins_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    cke_d  = cke;
    cs_n_d = 2'b11;
    pins_d = PIN_NOP;
    addr_d = '0;
    if (drive) begin
      unique case (mode)
        MODE_PALL: begin
          cs_n_d = ~tgt; pins_d = PIN_PALL; addr_d[AP_BIT] = 1'b1;
        end
        MODE_AREF: begin cs_n_d = ~tgt; pins_d = PIN_AREF; end
        MODE_LMR:  begin cs_n_d = ~tgt; pins_d = PIN_LMR; addr_d = mval; end
        MODE_CKE_ON:            cke_d = cke | tgt;
        MODE_SELF, MODE_PDOWN:  cke_d = cke & ~tgt;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke  <= 2'b00;
      cs_n <= 2'b11;
      pins <= PIN_NOP;
      addr <= '0;
    end else begin
      if (drive) cke <= cke_d;
      cs_n <= cs_n_d;
      pins <= pins_d;
      addr <= addr_d;
    end
  end
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdseq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int TF_W   = 4,
  parameter int RC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_word,
  input  logic [31:0]       timing_word,
  output logic [7:0]        status,
  output logic [1:0]        sd_cke,
  output logic [1:0]        sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr
);
  localparam int BUSY_BIT = 5;

  mode_e             dec_mode, mode_q;
  logic [1:0]        dec_tgt, tgt_q;
  logic [RC_W-1:0]   dec_rc, rleft_q;
  logic [ADDR_W-1:0] dec_mval, mval_q;
  logic [TF_W-1:0]   dec_trc, dec_trp, dec_tmrd, trc_q, trp_q, tmrd_q;
  state_e            state_q, state_d;
  logic              accept, t_zero, t_load, rleft_dec, drive;
  logic [TF_W-1:0]   t_val;
  logic [2:0]        pins;

  sdseq_decode #(.ADDR_W(ADDR_W), .TF_W(TF_W), .RC_W(RC_W)) u_dec (
    .cmd_word(cmd_word), .timing_word(timing_word),
    .mode(dec_mode), .tgt(dec_tgt), .rcount(dec_rc), .mval(dec_mval),
    .t_rc(dec_trc), .t_rp(dec_trp), .t_mrd(dec_tmrd)
  );

  assign accept = cmd_wr && (state_q == ST_IDLE);
  assign drive  = (state_q == ST_ISSUE);

  always_comb begin
    state_d   = state_q;
    t_load    = 1'b0;
    rleft_dec = 1'b0;
    t_val     = trp_q;
    unique case (mode_q)
      MODE_AREF: t_val = trc_q;
      MODE_LMR:  t_val = tmrd_q;
      default:   t_val = trp_q;
    endcase
    unique case (state_q)
      ST_IDLE:
        if (accept && (dec_tgt != 2'b00)) state_d = ST_ISSUE;
      ST_ISSUE: begin
        if (mode_q inside {MODE_PALL, MODE_AREF, MODE_LMR}) begin
          state_d = ST_WAIT;
          t_load  = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_WAIT:
        if (t_zero) begin
          if ((mode_q == MODE_AREF) && (rleft_q != '0)) begin
            state_d   = ST_ISSUE;
            rleft_dec = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NORMAL;
      tgt_q  <= '0;
      mval_q <= '0;
      trc_q  <= '0;
      trp_q  <= '0;
      tmrd_q <= '0;
    end else if (accept) begin
      mode_q <= dec_mode;
      tgt_q  <= dec_tgt;
      mval_q <= dec_mval;
      trc_q  <= dec_trc;
      trp_q  <= dec_trp;
      tmrd_q <= dec_tmrd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rleft_q <= '0;
    else if (accept)    rleft_q <= dec_rc;
    else if (rleft_dec) rleft_q <= rleft_q - 1'b1;
  end

  sdseq_timer #(.W(TF_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
    .run(state_q == ST_WAIT), .zero(t_zero)
  );

  sdseq_pins #(.ADDR_W(ADDR_W), .AP_BIT(10)) u_pins (
    .clk(clk), .rst_n(rst_n), .drive(drive), .mode(mode_q), .tgt(tgt_q),
    .mval(mval_q), .cke(sd_cke), .cs_n(sd_cs_n), .pins(pins), .addr(sd_addr)
  );

  assign {sd_ras_n, sd_cas_n, sd_we_n} = pins;

  always_comb begin
    status           = '0;
    status[BUSY_BIT] = (state_q != ST_IDLE);
  end
endmodule

// File: rtl/sdseq_checker.sv
module sdseq_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr,
  input logic              busy,
  input logic [1:0]        cke,
  input logic [1:0]        cs_n,
  input logic [2:0]        pins,
  input logic [ADDR_W-1:0] addr
);
  assert_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pins != 3'b111) |=> (pins == 3'b111));

  assert_cmd_targets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pins != 3'b111) |-> (cs_n != 2'b11));

  assert_pall_a10_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 3'b010) |-> addr[10]);

  assert_cmd_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pins != 3'b111) |-> busy);

  assert_busy_from_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_wr));

  assert_cke_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cke) |-> $past(busy));

  assert_idle_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n == 2'b11));
endmodule

bind sdram_cmd_seq sdseq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .busy(status[5]),
  .cke(sd_cke), .cs_n(sd_cs_n), .pins({sd_ras_n, sd_cas_n, sd_we_n}),
  .addr(sd_addr)
);

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;
  localparam int AW = 13;
  localparam int NOBS = 32;

  logic          clk, rst_n, cmd_wr;
  logic [31:0]   cmd_word, timing_word;
  logic [7:0]    status;
  logic [1:0]    sd_cke, sd_cs_n;
  logic          sd_ras_n, sd_cas_n, sd_we_n;
  logic [AW-1:0] sd_addr;

  int checks = 0, errors = 0;

  logic [2:0]    o_pin  [NOBS];
  logic [1:0]    o_cs   [NOBS];
  logic [1:0]    o_cke  [NOBS];
  logic          o_busy [NOBS];
  logic [AW-1:0] o_addr [NOBS];

  sdram_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .timing_word(timing_word), .status(status), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tw(input int tmrd, input int trc, input int trp);
    return 32'(tmrd) | (32'(trc) << 12) | (32'(trp) << 20);
  endfunction

  // write one word; returns right after the first negedge following acceptance
  task automatic send(input logic [31:0] w);
    cmd_word = w;
    cmd_wr   = 1'b1;
    @(negedge clk);
    cmd_wr   = 1'b0;
  endtask

  task automatic observe(input int n);
    for (int k = 0; k < n; k++) begin
      o_pin[k]  = {sd_ras_n, sd_cas_n, sd_we_n};
      o_cs[k]   = sd_cs_n;
      o_cke[k]  = sd_cke;
      o_busy[k] = status[5];
      o_addr[k] = sd_addr;
      @(negedge clk);
    end
  endtask

  function automatic int busy_fall(input int n);
    for (int k = 0; k < n; k++) if (!o_busy[k]) return k;
    return -1;
  endfunction

  task automatic t_reset;
    chk(status == 8'h00, "R1 status", status, 0);
    chk(sd_cke == 2'b00, "R1 cke", sd_cke, 0);
    chk(sd_cs_n == 2'b11, "R1 cs_n", sd_cs_n, 3);
    chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1 pins",
        {sd_ras_n, sd_cas_n, sd_we_n}, 7);
    chk(sd_addr == '0, "R1 addr", sd_addr, 0);
  endtask

  task automatic t_cke_on;
    send(32'h11);                       // clock enable, device 1
    chk(status == 8'h20, "R8 busy bit 5 after accept", status, 8'h20);
    @(negedge clk);
    observe(2);
    chk(o_cke[0] == 2'b01, "R2 cke dev1 only", o_cke[0], 1);
    chk(o_cs[0] == 2'b11 && o_pin[0] == 3'b111, "R11 cke carries no command",
        {o_cs[0], o_pin[0]}, 5'h1f);
    chk(o_busy[0] == 1'b0, "R8 busy clear after cke", o_busy[0], 0);
    send(32'h09);                       // clock enable, device 2
    @(negedge clk);
    observe(1);
    chk(o_cke[0] == 2'b11, "R2 cke dev2 added", o_cke[0], 3);
  endtask

  task automatic t_pall;
    timing_word = tw(1, 1, 3);
    send(32'h1A);                       // precharge both
    @(negedge clk);
    observe(8);
    chk(o_pin[0] == 3'b010, "R4 pall pins", o_pin[0], 3'b010);
    chk(o_addr[0][10] == 1'b1, "R4 pall A10", o_addr[0], 13'h400);
    chk(o_cs[0] == 2'b00, "R3 both selected", o_cs[0], 0);
    chk(o_pin[1] == 3'b111 && o_cs[1] == 2'b11, "R11 one cycle",
        {o_cs[1], o_pin[1]}, 5'h1f);
    chk(busy_fall(8) == 4, "R4 busy trp+1", busy_fall(8), 4);
  endtask

  task automatic t_aref;
    int n = 0, first = -1, second = -1, third = -1;
    timing_word = tw(1, 2, 1);
    send(32'h0B | (32'd2 << 5));        // refresh dev2, count 2 -> 3 commands
    @(negedge clk);
    observe(16);
    for (int k = 0; k < 16; k++) if (o_pin[k] == 3'b001) begin
      n++;
      if (n == 1) first = k;
      if (n == 2) second = k;
      if (n == 3) third = k;
      chk(o_cs[k] == 2'b01, "R3 dev2 only selected", o_cs[k], 1);
    end
    chk(n == 3, "R5 refresh count N+1", n, 3);
    chk(first == 0 && second == 4 && third == 8, "R5 spacing trc+2",
        second * 16 + third, 4 * 16 + 8);
    chk(busy_fall(16) == 11, "R5 busy after last refresh", busy_fall(16), 11);
    timing_word = tw(1, 0, 1);
    send(32'h1B);                       // single refresh, trc 0
    @(negedge clk);
    observe(4);
    chk(o_pin[0] == 3'b001 && o_pin[1] == 3'b111, "R5 single refresh",
        {o_pin[0], o_pin[1]}, 6'o17);
    chk(busy_fall(4) == 1, "R5 busy trc+1 single", busy_fall(4), 1);
  endtask

  task automatic t_lmr;
    timing_word = tw(5, 1, 1);
    send((32'h023 << 9) | 32'h1C);      // BL=3, CAS=2, both devices
    @(negedge clk);
    observe(10);
    chk(o_pin[0] == 3'b000, "R6 lmr pins", o_pin[0], 0);
    chk(o_addr[0] == 13'h023, "R6 mode value on address", o_addr[0], 13'h023);
    chk(o_addr[1] == 13'h000, "R6 address cleared after", o_addr[1], 0);
    chk(busy_fall(10) == 6, "R6 busy tmrd+1", busy_fall(10), 6);
  endtask

  task automatic t_ignore;
    int refs = 0, fall = -1;
    timing_word = tw(1, 1, 6);
    send(32'h1A);                       // precharge, trp 6
    @(negedge clk);
    for (int k = 0; k < 14; k++) begin
      if ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b001) refs++;
      if (!status[5] && fall < 0) fall = k;
      cmd_word = 32'h1B;
      cmd_wr   = (k == 1);             // refresh write during busy
      @(negedge clk);
    end
    cmd_wr = 1'b0;
    chk(refs == 0, "R9 write during busy ignored", refs, 0);
    chk(fall == 7, "R9 busy timing unchanged", fall, 7);
  endtask

  task automatic t_notgt;
    int bad = 0;
    send(32'h03 | (32'd3 << 5));        // refresh, no target
    chk(status == 8'h00, "R10 busy never set", status, 0);
    observe(6);
    for (int k = 0; k < 6; k++) if (o_busy[k] || o_cs[k] != 2'b11) bad++;
    chk(bad == 0, "R10 no command issued", bad, 0);
  endtask

  task automatic t_lowpower;
    send(32'h15);                       // self-refresh dev1
    @(negedge clk);
    observe(1);
    chk(o_cke[0] == 2'b10, "R7 self-refresh dev1 cke low", o_cke[0], 2);
    send(32'h0E);                       // power-down dev2
    @(negedge clk);
    observe(1);
    chk(o_cke[0] == 2'b00, "R7 power-down dev2 cke low", o_cke[0], 0);
    send(32'h19);                       // clock enable both
    @(negedge clk);
    send(32'h18);                       // normal mode, both
    @(negedge clk);
    observe(3);
    chk(o_cke[0] == 2'b11 && o_pin[0] == 3'b111 && o_cs[0] == 2'b11,
        "R7 normal mode no command", {o_cke[0], o_cs[0], o_pin[0]}, 7'h7f);
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_word = '0; timing_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cke_on();
    t_pall();
    t_aref();
    t_lmr();
    t_ignore();
    t_notgt();
    t_lowpower();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule